// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single register-style requests into bus cycles on an 8-bit asynchronous NAND flash interface. Each request is one of four kinds: a command byte, an address byte, a data byte to write, or a data byte to read. The block drives the chip enable, the two latch-select lines, the write and read strobes and the data bus for that one cycle. It returns the byte it captured when the request was a read.

A single packed timing word, which may be changed between requests, sets every phase length in clock cycles. These are the chip-enable lead time, the low and high phases of each strobe, the turnaround gap that ends each cycle, and how long the flash ready line is ignored after a command. A field programmed as zero is treated as one clock. A request that arrives while a cycle is running is held off through a ready/valid handshake and is never lost. A two-bit status output shows whether the sequencer is idle and whether the flash is ready. A single combined flag shows the device as ready only when both bits are set.

Top module: `nand_seq`

## Requirements
- R1: A request of kind 2'b00 (command) produces one cycle with `nand_cle` high, `nand_ale` low, the request byte on `nand_dq_o` with `nand_dq_oe` high, and a single low pulse of `nand_we_n`. The reset command 0xFF takes this same path.
- R2: A request of kind 2'b01 (address) produces the same cycle with `nand_ale` high and `nand_cle` low. Kind 2'b10 (data write) produces it with both latch lines low.
- R3: For write kinds, `nand_we_n` stays low for WL clocks and the cycle then holds its outputs with strobes high for WH clocks. WL is timing bits 3:0 and WH is bits 7:4. `nand_re_n` never goes low at the same time as `nand_we_n`.
- R4: A request of kind 2'b11 (data read) keeps `nand_dq_oe` low and drives `nand_re_n` low for RL clocks (bits 11:8), followed by a high phase of RH clocks (bits 15:12). `nand_dq_i` is captured on the last low clock, and `rd_data` is presented with a one-clock `rd_valid` pulse in the first high-phase clock.
- R5: After the strobe high phase, the latch lines and `nand_dq_oe` drop. `nand_ce_n` stays low for a turnaround of TA clocks (bits 18:16), and then the sequencer returns to idle.
- R6: `nand_ce_n` goes low CE clocks (bits 25:24) before the strobe falls, and it is high whenever the sequencer is idle.
- R7: `status[1]` and `req_ready` are high exactly when the sequencer is idle. A request held valid during a cycle is accepted once the cycle ends, and it executes in full after the running cycle.
- R8: `status[0]` is `nand_rb_n` passed through a two-flop synchroniser. It is forced low for BD clocks (bits 23:19), counted from the end of each command cycle's strobe high phase. `dev_ready` is high only when both status bits are high.
- R9: Any timing field programmed as zero behaves as one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_i | input | 26 | Packed phase lengths in clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this clock when valid |
| req_kind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_data | input | DW | Byte to place on the bus |
| rd_valid | output | 1 | One-clock pulse with read result |
| rd_data | output | DW | Captured read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch select |
| nand_ale | output | 1 | Address latch select |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | DW | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_i | input | DW | Data bus in |
| nand_rb_n | input | 1 | Flash ready (high) / busy (low) |
| status | output | 2 | Bit 1 sequencer idle, bit 0 flash ready |
| dev_ready | output | 1 | Both status bits set |

## Verification
A new request can arrive in the same clocks in which a running cycle is still in its strobe or turnaround phase. The bench provokes this by keeping a second request valid straight after the first is accepted. It then checks that `req_ready` stays low, that exactly two write pulses appear, and that the first carries the first byte and the second carries the second byte. The end of a command cycle also overlaps the start of the ready hold-off. For each command, the bench counts every clock in which `status[0]` is low, both inside the cycle and after it, and compares the count with BD while the ready line is held high.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [25:0]   timing_i,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [DW-1:0] nand_dq_o,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_i,
  input  logic          nand_rb_n,
  output logic [1:0]    status,
  output logic          dev_ready
);
  localparam int CW = 5;
  localparam logic [1:0] K_CMD = 2'b00, K_ADR = 2'b01, K_RD = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_CEA, S_LOW, S_HIGH, S_TA} st_t;

  st_t            st;
  logic [CW-1:0]  cnt, busy_cnt;
  logic [1:0]     kind, rb_sync;
  logic [DW-1:0]  dat;

  function automatic logic [CW-1:0] eff(input logic [CW-1:0] v);
    return (v == '0) ? CW'(1) : v;
  endfunction

  wire            is_rd   = (kind == K_RD);
  wire            active  = (st == S_CEA) || (st == S_LOW) || (st == S_HIGH);
  wire            last    = (cnt == '0);
  wire [CW-1:0]   cea_len = eff({3'b0, timing_i[25:24]});
  wire [CW-1:0]   lo_len  = is_rd ? eff({1'b0, timing_i[11:8]})  : eff({1'b0, timing_i[3:0]});
  wire [CW-1:0]   hi_len  = is_rd ? eff({1'b0, timing_i[15:12]}) : eff({1'b0, timing_i[7:4]});
  wire [CW-1:0]   ta_len  = eff({2'b0, timing_i[18:16]});
  wire [CW-1:0]   bd_len  = eff(timing_i[23:19]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      kind     <= K_CMD;
      dat      <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      busy_cnt <= '0;
      rb_sync  <= 2'b00;
    end else begin
      rb_sync  <= {rb_sync[0], nand_rb_n};
      rd_valid <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (!last) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          kind <= req_kind;
          dat  <= req_data;
          cnt  <= cea_len - 1'b1;
          st   <= S_CEA;
        end
        S_CEA: if (last) begin
          cnt <= lo_len - 1'b1;
          st  <= S_LOW;
        end
        S_LOW: if (last) begin
          cnt <= hi_len - 1'b1;
          st  <= S_HIGH;
          if (is_rd) begin
            rd_data  <= nand_dq_i;
            rd_valid <= 1'b1;
          end
        end
        S_HIGH: if (last) begin
          cnt <= ta_len - 1'b1;
          st  <= S_TA;
          if (kind == K_CMD) busy_cnt <= bd_len;
        end
        S_TA: if (last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign nand_ce_n  = (st == S_IDLE);
  assign nand_cle   = active && (kind == K_CMD);
  assign nand_ale   = active && (kind == K_ADR);
  assign nand_we_n  = !((st == S_LOW) && !is_rd);
  assign nand_re_n  = !((st == S_LOW) && is_rd);
  assign nand_dq_oe = active && !is_rd;
  assign nand_dq_o  = dat;
  assign status     = {st == S_IDLE, rb_sync[1] && (busy_cnt == '0)};
  assign dev_ready  = &status;
endmodule

module nand_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic          nand_ce_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic [DW-1:0] nand_dq_o,
  input logic          nand_dq_oe,
  input logic [1:0]    status
);
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  a_r6_strobe_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_dq_o));
  a_r4_capture_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (nand_re_n && $past(!nand_re_n)));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && !nand_cle && !nand_ale && !nand_dq_oe));
  a_r8_busy_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_cle) |-> !status[0]);
endmodule

bind nand_seq nand_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
  .nand_dq_oe(nand_dq_oe), .status(status)
);

// File: tb/nand_seq_tb.sv
module nand_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [25:0] timing_i;
  logic        req_valid = 0, req_ready;
  logic [1:0]  req_kind = 0;
  logic [7:0]  req_data = 0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i = 0;
  logic        nand_rb_n = 1;
  logic [1:0]  status;
  logic        dev_ready;

  int total = 0, bad = 0, cyc = 0;
  int f_ce, f_bd, f_ta, f_rh, f_rl, f_wh, f_wl;

  nand_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic set_timing(int ce, int bd, int ta, int rh, int rl, int wh, int wl);
    f_ce = ce; f_bd = bd; f_ta = ta; f_rh = rh; f_rl = rl; f_wh = wh; f_wl = wl;
    timing_i = {2'(ce), 5'(bd), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(logic [1:0] k, logic [7:0] d);
    int n_cea = 0, n_lo = 0, n_hi = 0, n_ta = 0, n_nr = 0, rd_at = -1;
    bit seen = 0, lat_ok = 1, got_rd = 0, idle_ok;
    logic [7:0] rdv = 0;
    bit isrd = (k == 2'b11);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_kind = k; req_data = d;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready) begin
      if (!status[0]) n_nr++;
      if (nand_ce_n || status[1]) lat_ok = 0;
      if (rd_valid) begin got_rd = 1; rdv = rd_data; rd_at = seen ? n_hi + n_ta : -1; end
      if (!nand_we_n || !nand_re_n) begin
        n_lo++; seen = 1;
        if (nand_cle != (k == 2'b00) || nand_ale != (k == 2'b01)) lat_ok = 0;
        if (isrd ? (nand_dq_oe || !nand_we_n) : (!nand_dq_oe || nand_dq_o != d || !nand_re_n)) lat_ok = 0;
      end else if (!seen) n_cea++;
      else if (nand_cle || nand_ale || nand_dq_oe) n_hi++;
      else n_ta++;
      @(negedge clk);
    end
    idle_ok = nand_ce_n && status[1] && !nand_cle && !nand_ale;
    for (int i = 0; i < 40; i++) begin
      if (!status[0]) n_nr++;
      @(negedge clk);
    end
    chk(idle_ok, "R7 idle after cycle", idle_ok, 1);
    chk(lat_ok, (k == 2'b00) ? "R1 command cycle" : "R2 latch/data lines", lat_ok, 1);
    chk(n_cea == eff(f_ce), "R6 ce lead", n_cea, eff(f_ce));
    chk(n_lo == eff(isrd ? f_rl : f_wl), isrd ? "R4 read low" : "R3 write low", n_lo, eff(isrd ? f_rl : f_wl));
    if (isrd) begin
      chk(n_hi + n_ta == eff(f_rh) + eff(f_ta), "R4 read high+R5 turnaround", n_hi + n_ta, eff(f_rh) + eff(f_ta));
      chk(got_rd && rdv == nand_dq_i && rd_at == 0, "R4 read capture", rdv, nand_dq_i);
    end else begin
      chk(n_hi == eff(f_wh), "R3 write high", n_hi, eff(f_wh));
      chk(n_ta == eff(f_ta), "R5 turnaround", n_ta, eff(f_ta));
      chk(!got_rd, "R4 no read pulse on write", got_rd, 0);
    end
    chk(n_nr == ((k == 2'b00) ? eff(f_bd) : 0), "R8 busy window", n_nr, (k == 2'b00) ? eff(f_bd) : 0);
  endtask

  task automatic stall_test();
    int runs = 0;
    logic [7:0] seen_b [2];
    bit prev_low = 0, rdy_ok = 1;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_kind = 2'b10; req_data = 8'h3C;
    @(negedge clk);
    req_data = 8'hC3;
    while (!req_ready) begin
      if (!nand_we_n && !prev_low) begin if (runs < 2) seen_b[runs] = nand_dq_o; runs++; end
      prev_low = !nand_we_n;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    if (req_ready) rdy_ok = 0;
    while (!req_ready) begin
      if (!nand_we_n && !prev_low) begin if (runs < 2) seen_b[runs] = nand_dq_o; runs++; end
      prev_low = !nand_we_n;
      @(negedge clk);
    end
    chk(rdy_ok, "R7 second request accepted", rdy_ok, 1);
    chk(runs == 2, "R7 no dropped request", runs, 2);
    chk(runs == 2 && seen_b[0] == 8'h3C && seen_b[1] == 8'hC3, "R7 order kept", seen_b[1], 8'hC3);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    set_timing(1, 3, 2, 2, 3, 2, 3);
    repeat (4) @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !rd_valid,
        "R6 reset outputs", nand_ce_n, 1);
    chk(req_ready && status[1], "R7 reset idle", status[1], 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(dev_ready && status == 2'b11, "R8 ready after sync", status, 3);

    run_op(2'b00, 8'hFF);
    run_op(2'b01, 8'h12);
    run_op(2'b10, 8'hA5);
    nand_dq_i = 8'h5A;
    run_op(2'b11, 8'h00);

    set_timing(0, 0, 0, 0, 0, 0, 0);
    run_op(2'b00, 8'h90);
    nand_dq_i = 8'h81;
    run_op(2'b11, 8'h00);
    run_op(2'b10, 8'h7E);
    chk(1, "R9 zero fields covered", 1, 1);

    set_timing(3, 31, 7, 15, 15, 15, 15);
    run_op(2'b00, 8'h30);
    nand_dq_i = 8'hE7;
    run_op(2'b11, 8'h00);
    run_op(2'b01, 8'hFE);

    set_timing(2, 4, 1, 1, 1, 1, 1);
    stall_test();

    nand_rb_n = 0;
    @(negedge clk);
    chk(status[0], "R8 sync stage one", status[0], 1);
    @(negedge clk);
    chk(!status[0] && !dev_ready, "R8 busy after two flops", status[0], 0);
    nand_rb_n = 1;
    @(negedge clk);
    chk(!status[0], "R8 release stage one", status[0], 0);
    @(negedge clk);
    chk(status[0] && dev_ready, "R8 ready after two flops", status[0], 1);

    for (int n = 0; n < 150; n++) begin
      set_timing($urandom_range(0, 3), $urandom_range(0, 31), $urandom_range(0, 7),
                 $urandom_range(0, 15), $urandom_range(0, 15),
                 $urandom_range(0, 15), $urandom_range(0, 15));
      nand_dq_i = 8'($urandom);
      run_op(2'($urandom), 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule